// File: doc/BRIEF.md
# Pipelined ROM-less Cosine Synthesizer

This block is a direct digital frequency synthesizer that produces one cosine sample per clock without any lookup table. A 24-bit phase register advances by a frequency word every cycle. For a single cycle, a displacement can be added to the phase handed downstream. The accumulator itself is left unchanged, so the shift applies only to that one sample.

The 14 most significant phase bits are split into a 2-bit quadrant and a 12-bit position inside the quadrant. The position is folded so that quadrants 01 and 11 read it mirrored, and it is then turned into a small angle x, one quarter of the angle within the quadrant. cos(x) is approximated by a three-term series that uses only squaring hardware. The identity cos(4x) = 8cos⁴x − 8cos²x + 1 then expands it to the angle within the quadrant. A last stage applies the quadrant sign.

The whole datapath is ten registered stages. It accepts a new phase every clock and delivers a 12-bit two's-complement sample with a valid flag.

Top module: `rlcos_synth`

## Requirements
- R1: The accumulator starts at 0 after reset and advances by `freq_word` modulo 2^24 on every clock. The phase captured at the n-th clock edge after reset release (n = 1, 2, ...) is (n−1)·freq_word plus any displacement applied in that cycle.
- R2: When `adj_en` is high in a cycle, that cycle's captured phase is accumulator + `adj_disp` (mod 2^24); when it is low, the captured phase is the accumulator alone. The accumulator never absorbs the displacement, so samples before and after a one-cycle pulse are unshifted.
- R3: Let k be bits [23:10] of a captured phase. The sample derived from that phase lies within ±4 of round(2047·cos(2π·(k+0.5)/16384)).
- R4: A phase captured at clock edge e appears on `sample` right after edge e+9, which is the tenth register on its path. One new sample is produced per clock.
- R5: The sample is negative or zero when phase bits [23:22] are 01 or 10, and positive or zero when they are 00 or 11. Quadrants 01 and 11 use the complemented 12-bit position.
- R6: `sample` always lies in the range −2047 to +2047.
- R7: `sample_vld` is low until the tenth clock edge after reset release, goes high at that edge, and then stays high until the next reset.
- R8: A synchronous reset clears the accumulator and all pipeline registers: `sample` reads 0 and `sample_vld` reads 0 after a clock edge with `rst` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 24 | Phase increment added each clock |
| adj_en | input | 1 | Apply the displacement to this cycle's phase |
| adj_disp | input | 24 | Phase displacement used when `adj_en` is high |
| sample | output | 12 | Two's-complement cosine sample |
| sample_vld | output | 1 | High once the pipeline holds valid data |

## Verification
The first sweep steps the phase by exactly one 14-bit index per clock across all 16384 indices. This covers every quadrant edge, both ends of the mirrored range and the peak and zero crossings. A wrong fold or a mirror off by one would break continuity at the boundaries. A missing complement would flip sign in whole quadrants. Further runs use an irregular step, a negative step and a step near half the sample rate. Together with one-cycle displacement pulses, these expose a model and design that drift apart, or a displacement that leaks into the accumulator and shifts every later sample. A mid-run reset followed by a half-turn pulse on a frozen phase checks that the pulse lands on exactly one sample, ten edges after it is applied. A pipeline of the wrong depth would misalign every comparison and the valid flag.

// File: rtl/rlcos_synth.sv
module rlcos_synth #(
  parameter int ACC_W = 24,
  parameter int ANG_W = 12,
  parameter int OUT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ACC_W-1:0]        freq_word,
  input  logic                    adj_en,
  input  logic [ACC_W-1:0]        adj_disp,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sample_vld
);
  localparam int PW   = ANG_W + 1;
  localparam int XPW  = PW + 15;
  localparam int AMP  = (1 << (OUT_W - 1)) - 1;
  localparam int LAT  = 10;
  localparam logic [14:0] PI_Q13 = 15'd25736;

  logic [ACC_W-1:0] acc, ph1;
  logic [ANG_W-1:0] p2;
  logic [7:0]       sgn;
  logic [15:0]      x3, sq4, q5, sq5;
  logic [16:0]      c6, c2_7, c2_8, c4_8;
  logic [OUT_W-2:0] mag9;
  logic [3:0]       vcnt;

  logic [ANG_W+1:0] top2;
  logic [XPW-1:0]   xprod;
  logic [31:0]      sqx, sq2, t6;
  logic [16:0]      c6_n, d9, vc;
  logic [33:0]      c2p, c4p;
  logic signed [20:0] v9;
  logic [31:0]      sc;

  assign top2  = (ANG_W+2)'(ph1 >> (ACC_W - ANG_W - 2));
  assign xprod = {15'd0, p2, 1'b1} * {{PW{1'b0}}, PI_Q13};
  assign sqx   = {16'd0, x3} * {16'd0, x3};
  assign sq2   = {16'd0, sq4} * {16'd0, sq4};
  assign t6    = {16'd0, q5} * 32'd2731;
  assign c6_n  = 17'd65536 - {2'b00, sq5[15:1]} + {1'b0, 16'(t6 >> 16)};
  assign c2p   = {17'd0, c6} * {17'd0, c6};
  assign c4p   = {17'd0, c2_7} * {17'd0, c2_7};
  assign d9    = c2_8 - c4_8;
  assign v9    = 21'sd65536 - $signed({1'b0, d9, 3'b000});
  assign vc    = (v9 < 0) ? 17'd0 : v9[16:0];
  assign sc    = {15'd0, vc} * 32'(AMP) + 32'd32768;

  assign sample_vld = (vcnt == 4'(LAT));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      ph1    <= '0;
      p2     <= '0;
      sgn    <= '0;
      x3     <= '0;
      sq4    <= '0;
      q5     <= '0;
      sq5    <= '0;
      c6     <= '0;
      c2_7   <= '0;
      c2_8   <= '0;
      c4_8   <= '0;
      mag9   <= '0;
      sample <= '0;
      vcnt   <= '0;
    end else begin
      acc    <= acc + freq_word;
      ph1    <= acc + (adj_en ? adj_disp : '0);
      p2     <= top2[ANG_W] ? ~top2[ANG_W-1:0] : top2[ANG_W-1:0];
      sgn    <= {sgn[6:0], top2[ANG_W+1] ^ top2[ANG_W]};
      x3     <= 16'(xprod >> PW);
      sq4    <= 16'(sqx >> 16);
      q5     <= 16'(sq2 >> 16);
      sq5    <= sq4;
      c6     <= c6_n;
      c2_7   <= 17'(c2p >> 16);
      c4_8   <= 17'(c4p >> 16);
      c2_8   <= c2_7;
      mag9   <= (OUT_W-1)'(sc >> 16);
      sample <= sgn[7] ? -$signed({1'b0, mag9}) : $signed({1'b0, mag9});
      if (vcnt != 4'(LAT)) vcnt <= vcnt + 4'd1;
    end
  end
endmodule

// File: rtl/rlcos_chk.sv
module rlcos_chk #(
  parameter int OUT_W = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic signed [OUT_W-1:0] sample,
  input logic                    sample_vld,
  input logic [1:0]              ph_top
);
  localparam int AMP = (1 << (OUT_W - 1)) - 1;

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    sample_vld |=> sample_vld); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!sample_vld && sample == '0)); // R8

  AST_AMP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (sample >= -AMP) && (sample <= AMP)); // R6

  AST_SIGN_QUADRANT: assert property (@(posedge clk) disable iff (rst)
    (sample_vld && sample != '0) |-> ((sample < 0) == $past(ph_top[1] ^ ph_top[0], 9))); // R5
endmodule

bind rlcos_synth rlcos_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .sample(sample),
  .sample_vld(sample_vld),
  .ph_top(ph1[ACC_W-1:ACC_W-2])
);

// File: tb/sim_rlcos_synth.sv
module sim_rlcos_synth;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] freq_word = '0;
  logic adj_en = 1'b0;
  logic [23:0] adj_disp = '0;
  logic signed [11:0] sample;
  logic sample_vld;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [23:0] accm = '0;
  logic [23:0] hist [16];

  always #5 clk = ~clk;

  rlcos_synth u0 (
    .clk(clk), .rst(rst), .freq_word(freq_word), .adj_en(adj_en),
    .adj_disp(adj_disp), .sample(sample), .sample_vld(sample_vld)
  );

  function automatic int ideal(input logic [23:0] ph);
    real a, v;
    a = 2.0 * 3.14159265358979 * (real'(ph[23:10]) + 0.5) / 16384.0;
    v = 2047.0 * $cos(a);
    return $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
  endfunction

  task automatic chk(input string req, input int act, input int exp, input int tol);
    total++;
    if (act > exp + tol || act < exp - tol) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    logic [23:0] ph;
    int e;
    ph = accm + (adj_en ? adj_disp : 24'd0);
    hist[(cyc + 1) % 16] = ph;
    accm = accm + freq_word;
    @(posedge clk);
    #1;
    cyc++;
    chk("R7 valid", int'(sample_vld), (cyc >= 10) ? 1 : 0, 0);
    if (cyc >= 10) begin
      e = ideal(hist[(cyc - 9) % 16]);
      chk("R1 R3 R4 amplitude", int'(sample), e, 4);
      if (e > 4 || e < -4) chk("R5 sign", (sample < 0) ? 1 : 0, (e < 0) ? 1 : 0, 0);
      if (sample > 12'sd2047 || sample < -12'sd2047) chk("R6 range", int'(sample), 0, 2047);
    end
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic [23:0] fw, input int per, input logic [23:0] d);
    for (int i = 0; i < n; i++) begin
      freq_word = fw;
      adj_en = (per != 0) && (i % per == per - 1);
      adj_disp = d + 24'(i * 4099);
      step();
    end
    adj_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R8 reset sample", int'(sample), 0, 0);
    chk("R8 reset valid", int'(sample_vld), 0, 0);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    accm = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset sample", int'(sample), 0, 0);
    chk("R8 reset valid", int'(sample_vld), 0, 0);
    @(negedge clk);
    rst = 1'b0;
    run(16400, 24'h000400, 0, 24'h0);
    run(3000, 24'h012345, 97, 24'h155555);
    run(2000, 24'hFFFC00, 61, 24'hC00000);
    run(1000, 24'h7FFFFF, 0, 24'h0);
    do_reset();
    run(12, 24'h0, 0, 24'h0);
    freq_word = '0;
    adj_en = 1'b1;
    adj_disp = 24'h800000;
    step();
    adj_en = 1'b0;
    run(8, 24'h0, 0, 24'h0);
    chk("R2 before pulse", int'(sample), 2047, 4);
    step();
    chk("R2 half-turn pulse", int'(sample), -2047, 4);
    step();
    chk("R2 accumulator unshifted", int'(sample), 2047, 4);
    run(20, 24'h0, 0, 24'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog cyc=%0d actual=hung expected=finished", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule